// File: doc/BRIEF.md
# Multi-Width Add/Subtract Flag Generator

This block is the arithmetic status path of an integer execution unit. It adds or subtracts two 32-bit operands, with an optional incoming carry or borrow, at an operand width of 8, 16 or 32 bits. It returns the width-truncated result combinationally and derives six status flags from the operation: carry, overflow, sign, zero, auxiliary carry and parity.

When an update strobe is high, the flags are latched into a 32-bit status word at fixed bit positions. Three control bits in the same word are written only through a separate load path: direction, interrupt enable and trap. Arithmetic updates leave them untouched.

Carry, overflow and sign track the selected width. Auxiliary carry always comes from bit 3, and parity always comes from the low result byte, whatever the width.

Top module: `alu_flag_unit`

## Requirements
- R1: `size_sel` selects the width: 00 = 8 bits, 01 = 16 bits, 10 or 11 = 32 bits. Result bits at and above the selected width read 0.
- R2: With `sub_sel`=0, `result` = a + b + `carry_in`. With `sub_sel`=1, `result` = a − b − `carry_in`. Both are taken modulo 2^width, using only the operand bits inside the width.
- R3: Carry flag (status bit 0) is 1 on a carry out of the top bit of the width when adding, or on a borrow into that bit when subtracting, and 0 otherwise.
- R4: Overflow flag (status bit 11) is 1 when the operation overflows as a signed value at the selected width.
- R5: Sign flag (status bit 7) equals the top bit of the result at the selected width.
- R6: Zero flag (status bit 6) is 1 only when every result bit within the width is 0.
- R7: Auxiliary-carry flag (status bit 4) is 1 on a carry out of bit 3 (add) or a borrow into bit 3 (subtract), at every width.
- R8: Parity flag (status bit 2) is 1 when result bits 7:0 hold an even number of ones, at every width.
- R9: The arithmetic flags are written on the rising edge where `upd_en` is 1. Otherwise they hold their value.
- R10: `ctl_wr`=1 loads `dir_in`, `ien_in` and `trap_in` into status bits 10, 9 and 8 at the edge. An arithmetic update does not change these bits.
- R11: Status bit 1 always reads 1. Bits 3, 5 and 31:12 always read 0.
- R12: Synchronous reset sets the status word to 0x00000002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| sub_sel | input | 1 | 1 = subtract, 0 = add |
| carry_in | input | 1 | Incoming carry (add) or borrow (subtract) |
| size_sel | input | 2 | Operand width code |
| upd_en | input | 1 | Latch arithmetic flags at the next edge |
| ctl_wr | input | 1 | Load the three control bits |
| dir_in | input | 1 | Direction bit value to load |
| ien_in | input | 1 | Interrupt-enable bit value to load |
| trap_in | input | 1 | Trap bit value to load |
| result | output | 32 | Width-truncated result (combinational) |
| flags_q | output | 32 | Registered status word |

## Verification
On every cycle, the assertions check the following:
- the constant bits of the status word;
- the reset value;
- that the arithmetic and control fields hold when their strobes are low;
- that result bits above a narrow width stay clear;
- the consistency rules between flags: a zero result implies even parity and a clear sign.

Only the bench scenarios can show that each flag takes the right value. Examples are carry versus borrow at each width, overflow at bits 7, 15 and 31, and auxiliary carry and parity staying byte-bound in 16- and 32-bit operations. The bench compares every case against a model built from the requirements.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  // Operand width codes (R1)
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WALT = 2'b11
  } size_code_e;

  // Arithmetic flag bundle produced by the evaluator
  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } arith_flags_t;

  // Status word bit positions
  localparam int ST_W      = 32;
  localparam int POS_CRY   = 0;
  localparam int POS_ONE   = 1;
  localparam int POS_PAR   = 2;
  localparam int POS_AUX   = 4;
  localparam int POS_ZRO   = 6;
  localparam int POS_SGN   = 7;
  localparam int POS_TRP   = 8;
  localparam int POS_IEN   = 9;
  localparam int POS_DIR   = 10;
  localparam int POS_OVF   = 11;

  localparam logic [ST_W-1:0] ARITH_MASK =
    (ST_W'(1) << POS_CRY) | (ST_W'(1) << POS_PAR) | (ST_W'(1) << POS_AUX) |
    (ST_W'(1) << POS_ZRO) | (ST_W'(1) << POS_SGN) | (ST_W'(1) << POS_OVF);
  localparam logic [ST_W-1:0] CTL_MASK =
    (ST_W'(1) << POS_TRP) | (ST_W'(1) << POS_IEN) | (ST_W'(1) << POS_DIR);
  localparam logic [ST_W-1:0] ONE_MASK  = ST_W'(1) << POS_ONE;
  localparam logic [ST_W-1:0] LIVE_MASK = ARITH_MASK | CTL_MASK;
  localparam logic [ST_W-1:0] RST_WORD  = ONE_MASK;

endpackage

// File: rtl/afg_lane_adder.sv
module afg_lane_adder #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int NLANE = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic [NLANE-1:0]  lane_cout,
  output logic [NLANE-1:0]  lane_ctop,
  output logic              nib_c4
);

  // Subtraction runs as a + ~b + ~borrow; carries are then inverted borrows.
  logic [DATA_W-1:0] b_eff;
  logic [NLANE:0]    chain;

  assign b_eff    = sub ? ~b : b;
  assign chain[0] = cin ^ sub;

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    localparam int LO  = k * LANE_W;
    localparam int TOP = LO + LANE_W - 1;
    logic [LANE_W:0] part;

    assign part = {1'b0, a[LO +: LANE_W]} + {1'b0, b_eff[LO +: LANE_W]}
                + {{LANE_W{1'b0}}, chain[k]};
    assign sum[LO +: LANE_W] = part[LANE_W-1:0];
    assign chain[k+1]        = part[LANE_W];
    assign lane_cout[k]      = part[LANE_W];
    // Carry into the lane's top bit recovered from the half-sum
    assign lane_ctop[k]      = a[TOP] ^ b_eff[TOP] ^ part[LANE_W-1];
  end

  // Carry into bit 4, i.e. out of bit 3
  assign nib_c4 = a[4] ^ b_eff[4] ^ sum[4];

endmodule

// File: rtl/afg_flag_eval.sv
module afg_flag_eval
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int NLANE  = DATA_W / LANE_W,
  localparam int LIDX_W = (NLANE > 1) ? $clog2(NLANE) : 1
) (
  input  logic [DATA_W-1:0] sum,
  input  logic [NLANE-1:0]  lane_cout,
  input  logic [NLANE-1:0]  lane_ctop,
  input  logic              nib_c4,
  input  logic              sub,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] res_m,
  output arith_flags_t      flg
);

  logic [LIDX_W-1:0] msb_lane;
  logic [NLANE-1:0]  lane_keep;
  logic [NLANE-1:0]  lane_topbit;
  logic              cout_sel;
  logic              ctop_sel;

  // Width code -> index of the most significant active lane
  always_comb begin
    unique case (size_code_e'(size))
      SZ_BYTE: msb_lane = '0;
      SZ_HALF: msb_lane = (NLANE > 1) ? LIDX_W'(1) : '0;
      default: msb_lane = LIDX_W'(NLANE - 1);
    endcase
  end

  for (genvar k = 0; k < NLANE; k++) begin : g_mask
    assign lane_keep[k]            = (LIDX_W'(k) <= msb_lane);
    assign res_m[k*LANE_W +: LANE_W] = lane_keep[k] ? sum[k*LANE_W +: LANE_W]
                                                    : '0;
    assign lane_topbit[k]          = sum[k*LANE_W + LANE_W - 1];
  end

  assign cout_sel = lane_cout[msb_lane];
  assign ctop_sel = lane_ctop[msb_lane];

  always_comb begin
    flg     = '0;
    flg.cry = cout_sel ^ sub;
    flg.ovf = cout_sel ^ ctop_sel;
    flg.sgn = lane_topbit[msb_lane];
    flg.zro = ~|res_m;
    flg.par = ~^res_m[7:0];
    flg.aux = nib_c4 ^ sub;
  end

endmodule

// File: rtl/afg_status_reg.sv
module afg_status_reg
  import alu_flag_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            upd_en,
  input  arith_flags_t    flg,
  input  logic            ctl_wr,
  input  logic            dir_in,
  input  logic            ien_in,
  input  logic            trap_in,
  output logic [ST_W-1:0] st_q
);

  logic [ST_W-1:0] st_d;
  logic [ST_W-1:0] st_raw;

  always_comb begin
    st_raw = st_q;
    if (upd_en) begin
      st_raw[POS_CRY] = flg.cry;
      st_raw[POS_PAR] = flg.par;
      st_raw[POS_AUX] = flg.aux;
      st_raw[POS_ZRO] = flg.zro;
      st_raw[POS_SGN] = flg.sgn;
      st_raw[POS_OVF] = flg.ovf;
    end
    if (ctl_wr) begin
      st_raw[POS_DIR] = dir_in;
      st_raw[POS_IEN] = ien_in;
      st_raw[POS_TRP] = trap_in;
    end
    st_d = (st_raw & LIVE_MASK) | ONE_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= RST_WORD;
    else     st_q <= st_d;
  end

  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
    ((st_q & ~LIVE_MASK) == ONE_MASK)); // R11

  AST_RESET_WORD: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (st_q == RST_WORD)); // R12

  AST_ARITH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(st_q & ARITH_MASK)); // R9

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctl_wr |=> $stable(st_q & CTL_MASK)); // R10

  AST_ZERO_PARITY: assert property (@(posedge clk) disable iff (rst)
    st_q[POS_ZRO] |-> st_q[POS_PAR]); // R8

  AST_ZERO_NO_SIGN: assert property (@(posedge clk) disable iff (rst)
    st_q[POS_ZRO] |-> !st_q[POS_SGN]); // R5

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int NLANE = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              sub_sel,
  input  logic              carry_in,
  input  logic [1:0]        size_sel,
  input  logic              upd_en,
  input  logic              ctl_wr,
  input  logic              dir_in,
  input  logic              ien_in,
  input  logic              trap_in,
  output logic [DATA_W-1:0] result,
  output logic [ST_W-1:0]   flags_q
);

  logic [DATA_W-1:0] sum;
  logic [NLANE-1:0]  lane_cout;
  logic [NLANE-1:0]  lane_ctop;
  logic              nib_c4;
  arith_flags_t      flg;

  afg_lane_adder #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_add (
    .a(opnd_a), .b(opnd_b), .sub(sub_sel), .cin(carry_in),
    .sum(sum), .lane_cout(lane_cout), .lane_ctop(lane_ctop), .nib_c4(nib_c4)
  );

  afg_flag_eval #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_eval (
    .sum(sum), .lane_cout(lane_cout), .lane_ctop(lane_ctop), .nib_c4(nib_c4),
    .sub(sub_sel), .size(size_sel), .res_m(result), .flg(flg)
  );

  afg_status_reg u_st (
    .clk(clk), .rst(rst), .upd_en(upd_en), .flg(flg),
    .ctl_wr(ctl_wr), .dir_in(dir_in), .ien_in(ien_in), .trap_in(trap_in),
    .st_q(flags_q)
  );

  AST_BYTE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (size_sel == SZ_BYTE) |-> (result[DATA_W-1:LANE_W] == '0)); // R1

  AST_HALF_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (size_sel == SZ_HALF) |-> (result[DATA_W-1:2*LANE_W] == '0)); // R1

endmodule

// File: tb/tb_alu_flag_unit.sv
module tb_alu_flag_unit;

  logic        clk = 0;
  logic        rst = 1;
  logic [31:0] opnd_a = 0, opnd_b = 0;
  logic        sub_sel = 0, carry_in = 0;
  logic [1:0]  size_sel = 0;
  logic        upd_en = 0, ctl_wr = 0, dir_in = 0, ien_in = 0, trap_in = 0;
  logic [31:0] result, flags_q;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic e_dir = 0, e_ien = 0, e_trp = 0;
  logic [31:0] exp_flags = 32'h2;

  alu_flag_unit dut (.*);

  always #5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Reference model built from R1..R8
  task automatic model(input logic [31:0] a, b, input logic s, ci,
                       input logic [1:0] sz, output logic [31:0] res,
                       output logic [31:0] ar);
    int w;
    logic [31:0] m, am, bm;
    logic [33:0] full;
    logic cf, of, sf, zf, af, pf, sa, sb, sr;
    w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
    am = a & m; bm = b & m;
    if (!s) begin
      full = {2'b0, am} + {2'b0, bm} + {33'b0, ci};
      cf = full[w];
      af = ({1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'b0, ci}) > 5'd15;
    end else begin
      full = {2'b0, am} - {2'b0, bm} - {33'b0, ci};
      cf = ({2'b0, am} < ({2'b0, bm} + {33'b0, ci}));
      af = ({1'b0, a[3:0]} < ({1'b0, b[3:0]} + {4'b0, ci}));
    end
    res = full[31:0] & m;
    sa = am[w-1]; sb = bm[w-1]; sr = res[w-1];
    of = s ? (sa != sb && sr != sa) : (sa == sb && sr != sa);
    sf = sr;
    zf = (res == 0);
    pf = ~^res[7:0];
    ar = 32'h0;
    ar[0] = cf; ar[2] = pf; ar[4] = af; ar[6] = zf; ar[7] = sf; ar[11] = of;
  endtask

  function automatic logic [31:0] pack(logic [31:0] ar);
    return ar | 32'h2 | ({21'b0, e_dir, e_ien, e_trp, 8'b0});
  endfunction

  // One arithmetic operation with flag update; checks result and status word
  task automatic do_op(string tag, logic [31:0] a, b, logic s, ci, logic [1:0] sz);
    logic [31:0] er, ea;
    model(a, b, s, ci, sz, er, ea);
    @(negedge clk);
    opnd_a = a; opnd_b = b; sub_sel = s; carry_in = ci; size_sel = sz; upd_en = 1;
    #1 check({tag, " result"}, result, er);
    @(negedge clk);
    upd_en = 0;
    exp_flags = pack(ea);
    check({tag, " flags"}, flags_q, exp_flags);
  endtask

  task automatic t_reset();
    check("R12 reset word", flags_q, 32'h0000_0002);
  endtask

  task automatic t_add_widths();
    do_op("R1 R4 add8 ovf upper ignored", 32'hABCD_127F, 32'h5555_5501, 0, 0, 2'b00);
    do_op("R3 R6 R7 add16 wrap zero", 32'h1234_FFFF, 32'h0000_0001, 0, 0, 2'b01);
    do_op("R4 R5 add32 ovf", 32'h7FFF_FFFF, 32'h0000_0001, 0, 0, 2'b10);
    do_op("R2 R3 add32 carry-in", 32'hFFFF_FFFF, 32'h0000_0000, 0, 1, 2'b10);
    do_op("R1 code11 as 32", 32'h8000_0000, 32'h8000_0000, 0, 0, 2'b11);
  endtask

  task automatic t_sub_widths();
    do_op("R3 sub8 borrow", 32'h0000_0000, 32'h0000_0001, 1, 0, 2'b00);
    do_op("R4 sub8 ovf", 32'h0000_0080, 32'h0000_0001, 1, 0, 2'b00);
    do_op("R2 sub16 borrow-in", 32'h0000_1000, 32'h0000_0FFF, 1, 1, 2'b01);
    do_op("R6 sub32 equal", 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1, 0, 2'b10);
    do_op("R4 sub32 ovf", 32'h8000_0000, 32'h0000_0001, 1, 0, 2'b10);
  endtask

  task automatic t_byte_bound();
    do_op("R7 aux in 32bit add", 32'h1000_000F, 32'h0000_0001, 0, 0, 2'b10);
    do_op("R7 aux borrow 16bit", 32'h0000_0100, 32'h0000_0001, 1, 0, 2'b01);
    do_op("R8 parity low byte only", 32'h00FF_0003, 32'h0000_0000, 0, 0, 2'b10);
    do_op("R8 parity odd", 32'h0001_0001, 32'h0000_0000, 0, 0, 2'b10);
  endtask

  task automatic t_sweep();
    logic [31:0] x = 32'h1357_9BDF;
    for (int i = 0; i < 24; i++) begin
      logic [31:0] y;
      x = {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
      y = {x[15:0], x[31:16]} ^ 32'hA5C3_0F96;
      do_op("R2 R3 R4 sweep", x, y, i[0], i[2], i[4:3]);
    end
  endtask

  task automatic t_hold();
    @(negedge clk);
    opnd_a = 32'hFFFF_FFFF; opnd_b = 32'h1; sub_sel = 0; size_sel = 2'b10; upd_en = 0;
    @(negedge clk);
    @(negedge clk);
    check("R9 hold without upd_en", flags_q, exp_flags);
  endtask

  task automatic t_ctl();
    @(negedge clk);
    ctl_wr = 1; dir_in = 1; ien_in = 0; trap_in = 1;
    @(negedge clk);
    ctl_wr = 0; dir_in = 0; trap_in = 0;
    e_dir = 1; e_ien = 0; e_trp = 1;
    exp_flags = (exp_flags & ~32'h700) | 32'h500;
    check("R10 ctl load", flags_q, exp_flags);
    do_op("R10 ctl kept over arith", 32'h0000_0001, 32'h0000_0001, 0, 0, 2'b00);
    @(negedge clk);
    ctl_wr = 1; dir_in = 0; ien_in = 1; trap_in = 0; upd_en = 0;
    @(negedge clk);
    ctl_wr = 0;
    e_dir = 0; e_ien = 1; e_trp = 0;
    exp_flags = (exp_flags & ~32'h700) | 32'h200;
    check("R10 ctl reload", flags_q, exp_flags);
    check("R11 fixed bits", flags_q & ~32'h0000_0FD5, 32'h0000_0002);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_add_widths();
    t_sub_widths();
    t_byte_bound();
    t_hold();
    t_ctl();
    t_sweep();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule